// File: doc/BRIEF.md
# Interrupt Gate with Holdoff Timer

This block produces the single interrupt line that goes to a host processor. The host owns the pending-status and mask registers, and this block receives them as input vectors. It combines them with a global enable bit and a holdoff timer. The line is raised when any source is both pending and unmasked, the enable bit is set, and the holdoff timer has reached zero.

Each time the host reads the status register, a one-cycle pulse reloads the holdoff timer with a programmed count. The timer then counts down in steps of about 100 microseconds. A prescaler, whose divide ratio is a parameter, derives these steps from the clock. The timer is used in one of two modes. In the immediate mode the countdown starts at the reload. In the deferred mode it waits until the first unmasked pending source appears while the enable bit is set. This lets the host bound its interrupt rate after servicing a batch of events.

Two 32-bit read/write registers sit on a simple register bus. Writes take effect at the clock edge, and read data is combinational from the address. The enable register is at offset 0x0 and the holdoff register is at offset 0x4.

Top module: `irq_gate`

## Requirements
- R1: Bit 0 of the enable register (offset 0x0) gates the output: while it is 0, `irq_out` stays low. Bits 31..1 read as zero whatever was written.
- R2: `irq_out` is high only when at least one bit position has both `irq_status` and `irq_mask` set. A pending source whose mask bit is 0 does not raise it.
- R3: The holdoff register (offset 0x4) holds the count in bits 7..0 and the mode bit in bit 8 (0 = immediate, 1 = deferred). Bits 31..9 read as zero. Any other offset reads as zero.
- R4: A pulse on `status_rd` loads the timer with the programmed count C. In immediate mode with the enable bit set, `irq_out` is suppressed until exactly C·TICK_DIV clock edges have passed after the loading edge.
- R5: While the enable bit is 0, the countdown and its prescaler stand still. After re-enabling, only the remaining enabled edges are needed to finish.
- R6: In deferred mode the countdown does not advance until an edge at which an unmasked source is pending and the enable bit is set. From that edge, C·TICK_DIV further edges bring the timer to zero.
- R7: A programmed count of 0 imposes no holdoff. `irq_out` may be high on the cycle right after the status read.
- R8: Both the hard reset (`rst_n` low) and the synchronous soft reset (`soft_rst`) clear both registers and the timer.
- R9: A status read while a countdown is in progress reloads the full count. The C·TICK_DIV window restarts from that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| status_rd | input | 1 | One-cycle pulse: the host read the status register |
| irq_status | input | N_SRC | Pending interrupt sources |
| irq_mask | input | N_SRC | Per-source mask, 1 = source allowed |
| irq_out | output | 1 | Gated interrupt line to the host |

## Verification
The gating function is tried with these source patterns:
- all sources pending and unmasked;
- a single source both pending and unmasked;
- a pending source whose mask bit is clear;
- all sources pending with every mask bit clear.

Together these separate an AND-then-OR reduction from an OR of status alone, and from a wrong bit pairing. The holdoff is measured edge-exactly on both sides of its expiry, in both modes. It is also measured across a disabled pause and across a reload in mid-count, which tells a frozen prescaler from a free-running one and a reload from a no-op. The deferred mode is probed after a long idle gap with no pending source, where a design that ignored the mode bit would already have expired.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned OFS_ENABLE = 0;
   localparam int unsigned OFS_HOLD   = 4;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
   parameter int unsigned DIV = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   input  logic run,
   input  logic restart,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_pass
         assign tick = run & ~restart;
      end else begin : g_div
         localparam int unsigned W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] ctr;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ctr <= '0;
            else if (srst | restart) ctr <= '0;
            else if (run)            ctr <= (ctr == LAST) ? '0 : ctr + W'(1);
         end

         assign tick = run & ~restart & (ctr == LAST);

         // R5: a prescaler of ratio two or more never ticks on two edges in a row
         p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
   parameter int unsigned HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              load,
   input  logic [HOLD_W-1:0] load_val,
   input  logic              load_mode,
   input  logic              enable,
   input  logic              pending,
   input  logic              tick,
   output logic              restart,
   output logic              run,
   output logic              idle
);
   logic [HOLD_W-1:0] cnt;
   logic              waiting;
   logic              running;
   logic              start;

   always_comb begin
      start   = waiting & enable & pending & ~load;
      restart = load | start;
      run     = running & enable;
      idle    = (cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0; waiting <= 1'b0; running <= 1'b0;
      end else if (srst) begin
         cnt <= '0; waiting <= 1'b0; running <= 1'b0;
      end else if (load) begin
         cnt     <= load_val;
         running <= ~load_mode & (load_val != '0);
         waiting <=  load_mode & (load_val != '0);
      end else if (start) begin
         running <= 1'b1;
         waiting <= 1'b0;
      end else if (run && tick) begin
         cnt <= cnt - HOLD_W'(1);
         if (cnt == HOLD_W'(1)) running <= 1'b0;
      end
   end

   // R4: a status read places the programmed count in the timer
   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !srst) |=> cnt == $past(load_val));
   // R4: each step lowers the count by exactly one
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !srst && run && tick) |=> cnt == $past(cnt) - HOLD_W'(1));
   // R5: without an enabled countdown the count holds
   p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !srst && !run) |=> $stable(cnt));
   // R6: deferred mode keeps waiting until a pending source appears
   p_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && !pending && !load && !srst) |=> waiting);
endmodule

// File: rtl/irq_gate_regs.sv
module irq_gate_regs
   import irq_gate_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic              gate_en,
   output logic              hold_mode,
   output logic [HOLD_W-1:0] hold_count
);
   logic sel_en, sel_hold;

   assign sel_en   = (addr == ADDR_W'(OFS_ENABLE));
   assign sel_hold = (addr == ADDR_W'(OFS_HOLD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_en <= 1'b0; hold_mode <= 1'b0; hold_count <= '0;
      end else if (srst) begin
         gate_en <= 1'b0; hold_mode <= 1'b0; hold_count <= '0;
      end else if (wr_en) begin
         if (sel_en)   gate_en <= wdata[0];
         if (sel_hold) {hold_mode, hold_count} <= wdata[HOLD_W:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_en)        rdata[0]        = gate_en;
      else if (sel_hold) rdata[HOLD_W:0] = {hold_mode, hold_count};
   end

   // R8: a soft reset leaves both registers cleared
   p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(srst) |-> (!gate_en && !hold_mode && hold_count == '0));
   // R3: bits above the mode bit never read as one
   p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[REG_W-1:HOLD_W+1] == '0);
endmodule

// File: rtl/irq_gate.sv
module irq_gate
   import irq_gate_pkg::*;
#(
   parameter int unsigned N_SRC    = 8,
   parameter int unsigned TICK_DIV = 10000,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned HOLD_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              status_rd,
   input  logic [N_SRC-1:0]  irq_status,
   input  logic [N_SRC-1:0]  irq_mask,
   output logic              irq_out
);
   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("irq_gate: N_SRC must be at least 1");
      end
      if (HOLD_W < 1 || HOLD_W > REG_W - 2) begin : g_bad_hold
         $error("irq_gate: HOLD_W must leave room for the mode bit");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("irq_gate: ADDR_W too narrow for the register offsets");
      end
   endgenerate

   logic              gate_en, hold_mode, pending;
   logic [HOLD_W-1:0] hold_count;
   logic              tick, restart, run, hold_idle;

   assign pending = |(irq_status & irq_mask);

   irq_gate_regs #(.ADDR_W(ADDR_W), .HOLD_W(HOLD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .srst(soft_rst), .wr_en(reg_wr),
      .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .gate_en(gate_en), .hold_mode(hold_mode), .hold_count(hold_count));

   irq_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .srst(soft_rst), .run(run),
      .restart(restart), .tick(tick));

   irq_holdoff #(.HOLD_W(HOLD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .srst(soft_rst), .load(status_rd),
      .load_val(hold_count), .load_mode(hold_mode), .enable(gate_en),
      .pending(pending), .tick(tick), .restart(restart), .run(run),
      .idle(hold_idle));

   assign irq_out = gate_en & pending & hold_idle;

   // R1: the enable bit cleared means a quiet line
   p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |-> !irq_out);
   // R2: the line needs an unmasked pending source
   p_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (|(irq_status & irq_mask)));
   // R4: a running holdoff keeps the line low
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_idle |-> !irq_out);
endmodule

// File: tb/irq_gate_tb.sv
module irq_gate_tb;
   localparam int DIV = 4;
   localparam logic [3:0] A_EN = 4'h0, A_HOLD = 4'h4, A_NONE = 4'h8;

   logic        clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
   logic        reg_wr = 1'b0, status_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [7:0]  irq_status = '0, irq_mask = '0;
   logic        irq_out;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   irq_gate #(.N_SRC(8), .TICK_DIV(DIV), .ADDR_W(4), .HOLD_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .status_rd(status_rd), .irq_status(irq_status), .irq_mask(irq_mask),
      .irq_out(irq_out));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
      @(negedge clk); reg_addr = a; #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic status_read;
      @(negedge clk); status_rd = 1'b1;
      @(negedge clk); status_rd = 1'b0;
   endtask

   task automatic t_reset;
      irq_status = 8'hFF; irq_mask = 8'hFF;
      rd_chk("R8 enable after hard reset", A_EN, 32'h0);
      rd_chk("R8 holdoff after hard reset", A_HOLD, 32'h0);
      check("R8 line low after hard reset", irq_out, 0);
   endtask

   task automatic t_regs;
      bus_wr(A_EN, 32'hFFFF_FFFF);
      rd_chk("R1 enable unused bits", A_EN, 32'h1);
      bus_wr(A_HOLD, 32'hFFFF_FFFF);
      rd_chk("R3 holdoff layout", A_HOLD, 32'h1FF);
      rd_chk("R3 other offset", A_NONE, 32'h0);
      bus_wr(A_HOLD, 32'h0);
      bus_wr(A_EN, 32'h0);
   endtask

   task automatic t_gate;
      irq_status = 8'hFF; irq_mask = 8'hFF; #1;
      check("R1 disabled blocks line", irq_out, 0);
      bus_wr(A_EN, 32'h1); #1;
      check("R1 enabled passes line", irq_out, 1);
      irq_mask = 8'h00; #1;
      check("R2 all masked", irq_out, 0);
      irq_status = 8'h10; irq_mask = 8'h10; #1;
      check("R2 single unmasked source", irq_out, 1);
      irq_status = 8'h01; irq_mask = 8'hFE; #1;
      check("R2 pending but masked", irq_out, 0);
   endtask

   task automatic t_zero;
      irq_status = 8'hFF; irq_mask = 8'hFF;
      bus_wr(A_HOLD, 32'h0);
      status_read; #1;
      check("R7 zero count no delay", irq_out, 1);
   endtask

   task automatic t_mode0;
      bus_wr(A_HOLD, 32'h3);
      status_read; #1;
      check("R4 suppressed after read", irq_out, 0);
      wait_n(11);
      check("R4 still held one edge early", irq_out, 0);
      wait_n(1);
      check("R4 released after C*DIV edges", irq_out, 1);
   endtask

   task automatic t_pause;
      bus_wr(A_HOLD, 32'h3);
      status_read;
      wait_n(4);
      bus_wr(A_EN, 32'h0);
      wait_n(20);
      bus_wr(A_EN, 32'h1);
      wait_n(5);
      check("R5 remaining count after pause", irq_out, 0);
      wait_n(1);
      check("R5 release after resumed count", irq_out, 1);
   endtask

   task automatic t_reload;
      bus_wr(A_HOLD, 32'h3);
      status_read;
      wait_n(8);
      status_read;
      wait_n(11);
      check("R9 reload extends holdoff", irq_out, 0);
      wait_n(1);
      check("R9 release after reload window", irq_out, 1);
   endtask

   task automatic t_mode1;
      irq_status = 8'h00;
      bus_wr(A_HOLD, 32'h102);
      status_read;
      wait_n(30);
      irq_status = 8'hFF; #1;
      check("R6 count waits for event", irq_out, 0);
      wait_n(1);
      wait_n(7);
      check("R6 held one edge early", irq_out, 0);
      wait_n(1);
      check("R6 release after event window", irq_out, 1);
   endtask

   task automatic t_soft;
      bus_wr(A_HOLD, 32'h1AB);
      status_read; #1;
      check("R8 holdoff running before soft reset", irq_out, 0);
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      rd_chk("R8 enable after soft reset", A_EN, 32'h0);
      rd_chk("R8 holdoff after soft reset", A_HOLD, 32'h0);
      bus_wr(A_EN, 32'h1); #1;
      check("R8 timer cleared by soft reset", irq_out, 1);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      t_reset;
      t_regs;
      t_gate;
      t_zero;
      t_mode0;
      t_pause;
      t_reload;
      t_mode1;
      t_soft;
      wait_n(2);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule